// File: doc/BRIEF.md
# Serial register write interface

This block is a write-only, three-wire serial slave that lets an external host load a small bank of 8-bit configuration registers. The host pulls an active-low select line, then toggles a serial clock while presenting one data bit per clock. The block oversamples all host lines with its own system clock, which runs at least four times faster than the fastest host clock. It captures a bit on each falling edge of the host clock.

Bits are grouped into 16-bit frames. Each frame is an 8-bit register address followed by 8 bits of data, both sent most-significant bit first. Every completed frame writes one register, and several frames may follow each other while the select line stays low. An incomplete frame left over when the select line rises is dropped.

The register contents drive a flat parallel output for the rest of the chip. Three things return every register to its parameterised default: the synchronous system reset, an external defaults-load pin, and a self-clearing command bit inside register 0.

Top module: `serwr_regbank`

## Requirements
- R1: While `host_sel_n` is high, `host_clk` edges shift nothing in and cause no write. Such edges also do not disturb the alignment of the next window.
- R2: `host_dat` is captured on each falling edge of `host_clk`. The first eight bits are the address, A7 first. The next eight bits are the data, D7 first.
- R3: A write happens only on the 16th falling edge of a frame. The new register value appears on `reg_out` no later than the fifth rising `clk` edge after that falling edge. After 15 edges, `reg_out` is unchanged.
- R4: Several 16-bit frames may be sent within one low period of `host_sel_n`, and each complete frame performs its own write.
- R5: When `host_sel_n` rises in the middle of a frame, the partial bits cause no write. The next window starts at a frame boundary.
- R6: Holding `defaults_load` high for at least two `clk` cycles loads every register with its default.
- R7: A frame with address 0x00 and data bit 7 set loads every register with its default. That frame's data is not stored, and bit 7 of register 0 (`reg_out[7]`) always reads 0.
- R8: A frame whose address is NUM_REGS or higher changes no register.
- R9: Capture is correct for uneven host clock duty cycles and slow host clocks, provided each host clock phase lasts at least two `clk` periods.
- R10: While `rst_n` is low at a rising `clk` edge, every register takes its default value. The defaults sit in `reg_out` as register i at bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the host serial clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| host_clk | input | 1 | Host serial clock; data is captured on its falling edge |
| host_sel_n | input | 1 | Active-low frame window select from the host |
| host_dat | input | 1 | Serial data from the host |
| defaults_load | input | 1 | Asynchronous active-high request to restore defaults |
| reg_out | output | NUM_REGS*8 | Flat register contents, register i at bits [8i+7:8i] |

## Verification
A slipped bit counter or a badly ordered shift register shows up at the first completed frame. The wrong register byte changes, or the right byte takes a rotated value, on `reg_out` within five system clocks of the 16th host edge. If the counter is not cleared when the select line rises, the error shows up in the next window as a misaligned write. A broken reset path appears the first time a default is expected, and a write that should have been dropped appears as an unexpected byte change. Because the shift state is not visible directly, every check compares `reg_out` against a model that the bench builds from the rules above.

// File: rtl/serwr_pkg.sv
// Package: shared constants and the write request type for the serial
// register write interface. Frame geometry is fixed by the host protocol.
package serwr_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int FRAME_W   = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam int SRST_ADDR = 0;
    localparam int SRST_BIT  = 7;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/serwr_sync.sv
// Module: serwr_sync
// Multi-bit, multi-stage synchronizer for independent asynchronous inputs.
// Assumes each bit is sampled on its own (no bus coherency is needed) and
// that inputs hold each level for at least two clk periods.
module serwr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= async_in;
            end
        end else begin : g_next
            // Later stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/serwr_frame.sv
// Module: serwr_frame
// Detects falling edges of the synchronized host clock and shifts in one
// data bit per edge while the window select is low. On the last bit of a
// frame it emits a one-cycle write strobe with the address/data pair.
// Assumes the synchronized inputs share the same latency, so data keeps
// its setup relative to the clock edge.
module serwr_frame
    import serwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sclk_s,
    input  logic    sel_n_s,
    input  logic    dat_s,
    output logic    wr_stb,
    output wr_req_t wr_req
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic                 sclk_d;
    logic                 fall;
    logic [CNT_W-1:0]     bit_cnt;
    logic [FRAME_W-2:0]   shreg;

    // Delay the synchronized clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    assign fall = sclk_d & ~sclk_s;

    // Shift bits in, count the frame, and issue the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            wr_stb  <= 1'b0;
            wr_req  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (sel_n_s) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (fall) begin
                if (bit_cnt == LAST_BIT) begin
                    wr_stb  <= 1'b1;
                    wr_req  <= {shreg, dat_s};
                    bit_cnt <= '0;
                    shreg   <= '0;
                end else begin
                    shreg   <= {shreg[FRAME_W-3:0], dat_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R1: a strobe only follows a cycle with the window open.
    p_stb_needs_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!sel_n_s));

    // R3: a strobe is produced only at the final bit position.
    p_stb_on_last_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(bit_cnt) == LAST_BIT));

    // R4: back-to-back frames still produce separate single-cycle strobes.
    p_stb_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R5: a closed window always leaves the counter at a frame boundary.
    p_closed_window_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (bit_cnt == '0));
endmodule

// File: rtl/serwr_bank.sv
// Module: serwr_bank
// Register bank of NUM_REGS bytes, one per address from 0 upward. Holds the
// default table and decides between write, hardware defaults load and the
// self-clearing command bit in register 0. Assumes NUM_REGS >= 1 and
// DEFAULTS packed with register i at bits [8i+7:8i].
module serwr_bank
    import serwr_pkg::*;
#(
    parameter int                         NUM_REGS = 4,
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hwclr_s,
    input  logic                         wr_stb,
    input  wr_req_t                      wr_req,
    output logic [NUM_REGS*DATA_W-1:0]   reg_flat
);
    localparam int                        FLAT_W  = NUM_REGS * DATA_W;
    localparam logic [FLAT_W-1:0]         DEF_EFF =
        DEFAULTS & ~(FLAT_W'(1) << (SRST_ADDR * DATA_W + SRST_BIT));
    localparam logic [ADDR_W-1:0]         TOP_ADDR = ADDR_W'(NUM_REGS);

    logic soft_clr;
    logic load_def;

    // Decode the self-clearing defaults command in register 0.
    assign soft_clr = wr_stb && (wr_req.addr == ADDR_W'(SRST_ADDR))
                      && wr_req.data[SRST_BIT];
    assign load_def = hwclr_s | soft_clr;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] WMASK = (i == SRST_ADDR) ?
            ~(DATA_W'(1) << SRST_BIT) : {DATA_W{1'b1}};
        logic [DATA_W-1:0] q;

        // Hold one register: defaults on any reset source, else addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n || load_def)
                q <= DEF_EFF[i*DATA_W +: DATA_W];
            else if (wr_stb && (wr_req.addr == ADDR_W'(i)))
                q <= wr_req.data & WMASK;
        end

        assign reg_flat[i*DATA_W +: DATA_W] = q;
    end

    // R6: the defaults-load pin restores every register.
    p_hw_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hwclr_s |=> (reg_flat == DEF_EFF));

    // R7: the command bit restores every register.
    p_soft_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (reg_flat == DEF_EFF));

    // R7: the command bit never reads back as one.
    p_cmd_bit_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_flat[SRST_ADDR*DATA_W + SRST_BIT]);

    // R8: writes beyond the implemented range leave the bank untouched.
    p_unimpl_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wr_req.addr >= TOP_ADDR) && !hwclr_s) |=> $stable(reg_flat));
endmodule

// File: rtl/serwr_regbank.sv
// Module: serwr_regbank (top)
// Serial register write interface: synchronizes the host lines, assembles
// 16-bit address/data frames and writes them into the register bank.
// Assumes clk runs at least 4x the host clock and every host clock phase
// lasts at least two clk periods.
module serwr_regbank
    import serwr_pkg::*;
#(
    parameter int                         NUM_REGS    = 4,
    parameter int                         SYNC_STAGES = 2,
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS    = 32'h1CA5_3C05
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_clk,
    input  logic                       host_sel_n,
    input  logic                       host_dat,
    input  logic                       defaults_load,
    output logic [NUM_REGS*DATA_W-1:0] reg_out
);
    logic [3:0] raw;
    logic [3:0] synced;
    logic       wr_stb;
    wr_req_t    wr_req;

    assign raw = {defaults_load, host_dat, host_sel_n, host_clk};

    serwr_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0011)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw),
        .sync_out(synced)
    );

    serwr_frame u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (synced[0]),
        .sel_n_s(synced[1]),
        .dat_s  (synced[2]),
        .wr_stb (wr_stb),
        .wr_req (wr_req)
    );

    serwr_bank #(
        .NUM_REGS(NUM_REGS),
        .DEFAULTS(DEFAULTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hwclr_s (synced[3]),
        .wr_stb  (wr_stb),
        .wr_req  (wr_req),
        .reg_flat(reg_out)
    );
endmodule

// File: tb/serwr_regbank_bench.sv
module serwr_regbank_bench;
    localparam int          NREG = 4;
    localparam logic [31:0] DEFS = 32'h1CA5_3C05;
    localparam int          NVEC = 6;
    // Table of {address, data} frames; each is sent in its own window.
    localparam logic [15:0] VEC [NVEC] = '{16'h01A7, 16'h02FF, 16'h0300,
                                           16'h0112, 16'h0044, 16'h03C3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_clk = 1'b1;
    logic        host_sel_n = 1'b1;
    logic        host_dat = 1'b0;
    logic        defaults_load = 1'b0;
    logic [31:0] reg_out;
    logic [31:0] exp_regs = DEFS;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    serwr_regbank #(.NUM_REGS(NREG), .SYNC_STAGES(2), .DEFAULTS(DEFS)) u_serwr_regbank (
        .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .host_sel_n(host_sel_n),
        .host_dat(host_dat), .defaults_load(defaults_load), .reg_out(reg_out));

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model_wr(logic [7:0] a, logic [7:0] d);
        if (a < NREG) begin
            if (a == 8'h00 && d[7]) exp_regs = DEFS;
            else exp_regs[a*8 +: 8] = d;
        end
    endtask

    task automatic send_bit(logic b, int hi, int lo);
        host_dat = b;
        idle(hi);
        host_clk = 1'b0;
        idle(lo);
        host_clk = 1'b1;
    endtask

    task automatic send_bits(logic [15:0] v, int n, int hi, int lo);
        for (int k = 0; k < n; k++) send_bit(v[15-k], hi, lo);
    endtask

    task automatic open_win();
        host_sel_n = 1'b0;
        idle(4);
    endtask

    task automatic close_win();
        idle(4);
        host_sel_n = 1'b1;
        idle(4);
    endtask

    task automatic write_frame(logic [7:0] a, logic [7:0] d, int hi, int lo);
        open_win();
        send_bits({a, d}, 16, hi, lo);
        close_win();
        model_wr(a, d);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R10 defaults after reset", reg_out, DEFS);

        // R2: table of single-frame windows, MSB-first address then data.
        for (int i = 0; i < NVEC; i++) begin
            write_frame(VEC[i][15:8], VEC[i][7:0], 3, 3);
            chk("R2 table frame", reg_out, exp_regs);
        end

        // R3: nothing after 15 edges; value present within 5 clk of edge 16.
        open_win();
        send_bits(16'h025B, 15, 3, 2);
        idle(6);
        chk("R3 no write after 15 bits", reg_out, exp_regs);
        send_bit(1'b1, 3, 2);
        idle(3);
        model_wr(8'h02, 8'h5B);
        chk("R3 write latency", reg_out, exp_regs);
        close_win();

        // R4: three frames in one window.
        open_win();
        send_bits(16'h0211, 16, 3, 3);
        send_bits(16'h0322, 16, 3, 3);
        send_bits(16'h0133, 16, 3, 3);
        close_win();
        model_wr(8'h02, 8'h11);
        model_wr(8'h03, 8'h22);
        model_wr(8'h01, 8'h33);
        chk("R4 multiple frames in one window", reg_out, exp_regs);

        // R5: trailing partial frame dropped, next window aligned.
        open_win();
        send_bits(16'h0255, 16, 3, 3);
        send_bits(16'h0166, 7, 3, 3);
        close_win();
        model_wr(8'h02, 8'h55);
        chk("R5 partial frame dropped", reg_out, exp_regs);
        write_frame(8'h03, 8'h77, 3, 3);
        chk("R5 next window aligned", reg_out, exp_regs);

        // R1: host clock activity with select high.
        send_bits(16'h01EE, 16, 3, 3);
        idle(6);
        chk("R1 no write with select high", reg_out, exp_regs);
        send_bits(16'h0100, 5, 3, 3);
        write_frame(8'h01, 8'h99, 3, 3);
        chk("R1 alignment kept after idle edges", reg_out, exp_regs);

        // R8: unimplemented addresses.
        write_frame(8'h07, 8'hAA, 3, 3);
        chk("R8 address 0x07 ignored", reg_out, exp_regs);
        write_frame(8'hFF, 8'h01, 3, 3);
        chk("R8 address 0xFF ignored", reg_out, exp_regs);

        // R9: uneven duty cycles and a slow host clock.
        write_frame(8'h02, 8'h5C, 9, 2);
        chk("R9 long high phase", reg_out, exp_regs);
        write_frame(8'h03, 8'hA3, 2, 9);
        chk("R9 long low phase", reg_out, exp_regs);
        write_frame(8'h01, 8'h3E, 40, 40);
        chk("R9 slow host clock", reg_out, exp_regs);

        // R7: command bit restores defaults and reads back as zero.
        write_frame(8'h00, 8'h80, 3, 3);
        chk("R7 command restores defaults", reg_out, DEFS);
        chk("R7 command bit reads zero", {31'd0, reg_out[7]}, 32'd0);
        write_frame(8'h02, 8'h6D, 3, 3);
        write_frame(8'h00, 8'hFF, 3, 3);
        chk("R7 data not stored with command", reg_out, DEFS);

        // R6: defaults-load pin.
        write_frame(8'h01, 8'h42, 3, 3);
        write_frame(8'h00, 8'h7F, 3, 3);
        chk("R6 setup before pin", reg_out, exp_regs);
        defaults_load = 1'b1;
        idle(3);
        defaults_load = 1'b0;
        idle(4);
        exp_regs = DEFS;
        chk("R6 pin restores defaults", reg_out, DEFS);

        // R10: system reset mid-run.
        write_frame(8'h03, 8'h0F, 3, 3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        exp_regs = DEFS;
        chk("R10 system reset restores defaults", reg_out, DEFS);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule